// File: doc/BRIEF.md
# Cast-Type Drop Statistics Classifier

This block watches the header bytes of every received packet and decides whether the packet is link-layer multicast or broadcast, and whether it is network-layer multicast or broadcast. It reads the destination MAC address, the EtherType and the top byte of the IP destination address. When the upstream drop logic marks a packet as discarded by random early drop, the block adds one to the counters that match the packet's classes. There are four counters for each input port.

The header arrives one byte per cycle. A start strobe on the first byte carries the packet's parse mode and port number. A separate end-of-header strobe carries the drop flag. The parse mode says where byte 0 sits. In link-layer mode byte 0 is the first byte of the destination MAC. In IP mode byte 0 is the first byte of the IP header. Software uses a read port to fetch the four counters of one port. A read-clear control decides whether that read also zeroes the counters it returned.

Top module: `castdrop_stat`

## Requirements
- R1: After reset every counter of every port reads zero and `rd_valid` is low.
- R2: In link-layer mode (`hdr_mode`=0), a packet whose header bytes 0 to 5 are all 0xFF is classed as link-layer broadcast.
- R3: In link-layer mode, a packet is classed as link-layer multicast when bit 0 of byte 0 is set, all six MAC bytes arrived, and the packet is not link-layer broadcast. A header shorter than six bytes gets no link-layer class.
- R4: An IPv4 packet whose destination top byte has upper nibble 0xE is network-layer multicast. An IPv6 packet whose destination top byte is 0xFF is also network-layer multicast. That byte sits at header byte 30 (IPv4) or 38 (IPv6) in link-layer mode, and at byte 16 or 24 in IP mode.
- R5: An IPv4 packet whose destination top byte is 0xFF is network-layer broadcast. An IPv6 packet is never network-layer broadcast.
- R6: In IP mode (`hdr_mode`=1) the link-layer counters never change, whatever the header bytes are.
- R7: In link-layer mode a packet is IP only when bytes 12 and 13 are 0x0800 (IPv4) or 0x86DD (IPv6). In IP mode the upper nibble of byte 0 must be 4 or 6. Any other packet gets no network-layer class.
- R8: Each event updates only the counters of the port sampled with the start strobe. A read issued two cycles after the end-of-header strobe returns the updated value.
- R9: A packet whose end-of-header strobe has `hdr_drop` low changes no counter.
- R10: A read request (`rd_en`) returns `rd_valid` high the next cycle, together with the four counters of `rd_port`.
- R11: With `rd_clear` high, a read zeroes the four counters of that port after returning their values. With `rd_clear` low, a read leaves them unchanged.
- R12: If an increment and a clearing read hit the same counter in the same cycle, that counter ends at 1.
- R13: Counters are `CNT_W` bits wide and wrap to zero on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header byte valid |
| hdr_sop | input | 1 | Marks header byte 0 (with `hdr_valid`) |
| hdr_byte | input | 8 | Header byte |
| hdr_mode | input | 1 | Parse mode sampled at start: 0 link-layer, 1 IP |
| hdr_port | input | PORT_W | Port number sampled at start |
| hdr_eoh | input | 1 | End-of-header strobe, on a cycle without `hdr_valid` |
| hdr_drop | input | 1 | Random-early-drop flag, sampled with `hdr_eoh` |
| rd_en | input | 1 | Counter read request |
| rd_port | input | PORT_W | Port to read |
| rd_clear | input | 1 | Read-clear control |
| rd_valid | output | 1 | Read data valid |
| rd_l2_mcast | output | CNT_W | Link-layer multicast drops |
| rd_l2_bcast | output | CNT_W | Link-layer broadcast drops |
| rd_l3_mcast | output | CNT_W | Network-layer multicast drops |
| rd_l3_bcast | output | CNT_W | Network-layer broadcast drops |

## Verification
The assertions assume a well-formed header stream. Every header starts with `hdr_sop` and `hdr_valid` together. Its bytes are contiguous. `hdr_eoh` comes exactly once per header, on a cycle with `hdr_valid` low. Under these conditions the latched class mask of an event never holds two link-layer bits or two network-layer bits at once. The bench keeps to these rules by building every header in a single task that drives all bytes back to back. That task then raises the end-of-header strobe on its own idle cycle. Reads are issued only between packets, except in the one deliberate collision case.

// File: rtl/castdrop_pkg.sv
package castdrop_pkg;

  typedef enum logic {
    MODE_L2 = 1'b0,
    MODE_IP = 1'b1
  } parse_mode_e;

  typedef enum logic [1:0] {
    IPK_NONE = 2'd0,
    IPK_V4   = 2'd1,
    IPK_V6   = 2'd2
  } ip_kind_e;

  // class mask bit positions (read port order follows these)
  localparam int KIND_L2M = 0;
  localparam int KIND_L2B = 1;
  localparam int KIND_L3M = 2;
  localparam int KIND_L3B = 3;
  localparam int NKIND    = 4;

  // header byte positions
  localparam int IDX_W      = 6;
  localparam int IDX_MAX    = (1 << IDX_W) - 1;
  localparam int MAC_LAST   = 5;
  localparam int ETYPE_HI   = 12;
  localparam int ETYPE_LO   = 13;
  localparam int ETH_LEN    = 14;
  localparam int V4_DST_OFF = 16;
  localparam int V6_DST_OFF = 24;

  function automatic ip_kind_e kind_from_ethertype(input logic [15:0] et);
    case (et)
      16'h0800: return IPK_V4;
      16'h86DD: return IPK_V6;
      default:  return IPK_NONE;
    endcase
  endfunction

  function automatic ip_kind_e kind_from_version(input logic [7:0] b0);
    case (b0[7:4])
      4'h4:    return IPK_V4;
      4'h6:    return IPK_V6;
      default: return IPK_NONE;
    endcase
  endfunction

  // header index of the most significant destination-address byte
  function automatic logic [IDX_W-1:0] dst_top_index(input parse_mode_e md,
                                                     input ip_kind_e    kd);
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] off;
    base = (md == MODE_L2) ? IDX_W'(ETH_LEN) : '0;
    off  = (kd == IPK_V6) ? IDX_W'(V6_DST_OFF) : IDX_W'(V4_DST_OFF);
    return base + off;
  endfunction

  function automatic logic l3_is_mcast(input ip_kind_e kd, input logic [7:0] b);
    return ((kd == IPK_V4) && (b[7:4] == 4'hE)) ||
           ((kd == IPK_V6) && (b == 8'hFF));
  endfunction

  function automatic logic l3_is_bcast(input ip_kind_e kd, input logic [7:0] b);
    return (kd == IPK_V4) && (b == 8'hFF);
  endfunction

endpackage

// File: rtl/castdrop_parser.sv
module castdrop_parser
  import castdrop_pkg::*;
#(
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic              hdr_sop,
  input  logic [7:0]        hdr_byte,
  input  logic              hdr_mode,
  input  logic [PORT_W-1:0] hdr_port,
  input  logic              hdr_eoh,
  input  logic              hdr_drop,
  output logic              ev_valid,
  output logic [PORT_W-1:0] ev_port,
  output logic [NKIND-1:0]  ev_mask,
  output logic              ev_mode
);

  logic [IDX_W-1:0]  idx_q;
  parse_mode_e       mode_q;
  logic [PORT_W-1:0] port_q;
  ip_kind_e          kind_q;
  logic              da_ones_q;
  logic              da_full_q;
  logic              mc_bit_q;
  logic [7:0]        et_hi_q;
  logic              l3m_q;
  logic              l3b_q;

  // named per-byte events
  logic first_byte;
  logic next_byte;
  logic in_mac;
  logic at_mac_last;
  logic at_et_hi;
  logic at_et_lo;
  logic at_dst;
  logic byte_ones;

  assign first_byte  = hdr_valid && hdr_sop;
  assign next_byte   = hdr_valid && !hdr_sop;
  assign byte_ones   = (hdr_byte == 8'hFF);
  assign in_mac      = next_byte && (mode_q == MODE_L2) && (idx_q <= IDX_W'(MAC_LAST));
  assign at_mac_last = in_mac && (idx_q == IDX_W'(MAC_LAST));
  assign at_et_hi    = next_byte && (mode_q == MODE_L2) && (idx_q == IDX_W'(ETYPE_HI));
  assign at_et_lo    = next_byte && (mode_q == MODE_L2) && (idx_q == IDX_W'(ETYPE_LO));
  assign at_dst      = next_byte && (kind_q != IPK_NONE) &&
                       (idx_q == dst_top_index(mode_q, kind_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      mode_q    <= MODE_L2;
      port_q    <= '0;
      kind_q    <= IPK_NONE;
      da_ones_q <= 1'b0;
      da_full_q <= 1'b0;
      mc_bit_q  <= 1'b0;
      et_hi_q   <= '0;
      l3m_q     <= 1'b0;
      l3b_q     <= 1'b0;
    end else if (first_byte) begin
      idx_q     <= IDX_W'(1);
      mode_q    <= parse_mode_e'(hdr_mode);
      port_q    <= hdr_port;
      kind_q    <= hdr_mode ? kind_from_version(hdr_byte) : IPK_NONE;
      da_ones_q <= !hdr_mode && byte_ones;
      da_full_q <= 1'b0;
      mc_bit_q  <= hdr_byte[0];
      et_hi_q   <= '0;
      l3m_q     <= 1'b0;
      l3b_q     <= 1'b0;
    end else if (next_byte) begin
      idx_q <= (idx_q == IDX_W'(IDX_MAX)) ? idx_q : idx_q + 1'b1;
      if (in_mac)      da_ones_q <= da_ones_q && byte_ones;
      if (at_mac_last) da_full_q <= 1'b1;
      if (at_et_hi)    et_hi_q   <= hdr_byte;
      if (at_et_lo)    kind_q    <= kind_from_ethertype({et_hi_q, hdr_byte});
      if (at_dst) begin
        l3m_q <= l3_is_mcast(kind_q, hdr_byte);
        l3b_q <= l3_is_bcast(kind_q, hdr_byte);
      end
    end
  end

  // classification of the header seen so far
  logic [NKIND-1:0] cls_mask;
  always_comb begin
    cls_mask           = '0;
    cls_mask[KIND_L2B] = (mode_q == MODE_L2) && da_full_q && da_ones_q;
    cls_mask[KIND_L2M] = (mode_q == MODE_L2) && da_full_q && mc_bit_q && !da_ones_q;
    cls_mask[KIND_L3M] = l3m_q;
    cls_mask[KIND_L3B] = l3b_q;
  end

  // latch the result at end of header
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_port  <= '0;
      ev_mask  <= '0;
      ev_mode  <= 1'b0;
    end else begin
      ev_valid <= hdr_eoh && hdr_drop;
      if (hdr_eoh) begin
        ev_port <= port_q;
        ev_mask <= cls_mask;
        ev_mode <= mode_q;
      end
    end
  end

endmodule

// File: rtl/castdrop_bank.sv
module castdrop_bank
  import castdrop_pkg::*;
#(
  parameter int PORT_W = 3,
  parameter int CNT_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_valid,
  input  logic [PORT_W-1:0]           ev_port,
  input  logic [NKIND-1:0]            ev_mask,
  input  logic                        rd_en,
  input  logic [PORT_W-1:0]           rd_port,
  input  logic                        rd_clear,
  output logic                        rd_valid,
  output logic [NKIND-1:0][CNT_W-1:0] rd_cnt
);

  localparam int NUM_PORTS = 1 << PORT_W;
  localparam int NCNT      = NUM_PORTS * NKIND;

  // clear wins over the stored value; an increment in the same cycle survives
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cur,
                                                input logic inc,
                                                input logic clr);
    if (clr) return inc ? CNT_W'(1) : '0;
    return inc ? cur + 1'b1 : cur;
  endfunction

  logic [NCNT*CNT_W-1:0] cnt_flat;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic port_inc;
    logic port_clr;
    assign port_inc = ev_valid && (ev_port == PORT_W'(p));
    assign port_clr = rd_en && rd_clear && (rd_port == PORT_W'(p));
    for (genvar k = 0; k < NKIND; k++) begin : g_kind
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next(cnt_q, port_inc && ev_mask[k], port_clr);
      end
      assign cnt_flat[(p*NKIND+k)*CNT_W +: CNT_W] = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_cnt   <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        for (int k = 0; k < NKIND; k++) begin
          rd_cnt[k] <= cnt_flat[(int'(rd_port)*NKIND+k)*CNT_W +: CNT_W];
        end
      end
    end
  end

endmodule

// File: rtl/castdrop_stat.sv
module castdrop_stat
  import castdrop_pkg::*;
#(
  parameter int PORT_W = 3,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic              hdr_sop,
  input  logic [7:0]        hdr_byte,
  input  logic              hdr_mode,
  input  logic [PORT_W-1:0] hdr_port,
  input  logic              hdr_eoh,
  input  logic              hdr_drop,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] rd_port,
  input  logic              rd_clear,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_l2_mcast,
  output logic [CNT_W-1:0]  rd_l2_bcast,
  output logic [CNT_W-1:0]  rd_l3_mcast,
  output logic [CNT_W-1:0]  rd_l3_bcast
);

  logic                        ev_valid;
  logic [PORT_W-1:0]           ev_port;
  logic [NKIND-1:0]            ev_mask;
  logic                        ev_mode;
  logic [NKIND-1:0][CNT_W-1:0] rd_cnt;

  castdrop_parser #(.PORT_W(PORT_W)) u_parser (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_sop   (hdr_sop),
    .hdr_byte  (hdr_byte),
    .hdr_mode  (hdr_mode),
    .hdr_port  (hdr_port),
    .hdr_eoh   (hdr_eoh),
    .hdr_drop  (hdr_drop),
    .ev_valid  (ev_valid),
    .ev_port   (ev_port),
    .ev_mask   (ev_mask),
    .ev_mode   (ev_mode)
  );

  castdrop_bank #(.PORT_W(PORT_W), .CNT_W(CNT_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .ev_port  (ev_port),
    .ev_mask  (ev_mask),
    .rd_en    (rd_en),
    .rd_port  (rd_port),
    .rd_clear (rd_clear),
    .rd_valid (rd_valid),
    .rd_cnt   (rd_cnt)
  );

  assign rd_l2_mcast = rd_cnt[KIND_L2M];
  assign rd_l2_bcast = rd_cnt[KIND_L2B];
  assign rd_l3_mcast = rd_cnt[KIND_L3M];
  assign rd_l3_bcast = rd_cnt[KIND_L3B];

endmodule

// File: rtl/castdrop_chk.sv
module castdrop_chk
  import castdrop_pkg::*;
#(
  parameter int PORT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_eoh,
  input logic              hdr_drop,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              ev_valid,
  input logic [PORT_W-1:0] ev_port,
  input logic [NKIND-1:0]  ev_mask,
  input logic              ev_mode
);

  // R2 / R3: broadcast and multicast at link layer exclude each other
  p_l2_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !(ev_mask[KIND_L2M] && ev_mask[KIND_L2B]));

  // R5: network-layer classes exclude each other
  p_l3_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !(ev_mask[KIND_L3M] && ev_mask[KIND_L3B]));

  // R6: IP-mode events carry no link-layer class
  p_ip_mode_no_l2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_mode) |-> (ev_mask[KIND_L2B:KIND_L2M] == 2'b00));

  // R9: no event without a drop flag
  p_nodrop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_eoh && !hdr_drop) |=> !ev_valid);

  // R8: a dropped header yields an event on the next cycle
  p_drop_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_eoh && hdr_drop) |=> ev_valid);

  // R10: read response one cycle after the request, and only then
  p_read_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_read_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R8: the event port holds while no new end of header arrives
  p_port_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_eoh |=> $stable(ev_port));

endmodule

bind castdrop_stat castdrop_chk #(.PORT_W(PORT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hdr_eoh  (hdr_eoh),
  .hdr_drop (hdr_drop),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .ev_valid (ev_valid),
  .ev_port  (ev_port),
  .ev_mask  (ev_mask),
  .ev_mode  (ev_mode)
);

// File: tb/tb_castdrop_stat.sv
`timescale 1ns/1ps
module tb_castdrop_stat;

  localparam int PW = 3;
  localparam int CW = 8;
  localparam int NP = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hdr_valid = 1'b0, hdr_sop = 1'b0, hdr_mode = 1'b0;
  logic [7:0]    hdr_byte = '0;
  logic [PW-1:0] hdr_port = '0;
  logic          hdr_eoh = 1'b0, hdr_drop = 1'b0;
  logic          rd_en = 1'b0, rd_clear = 1'b0;
  logic [PW-1:0] rd_port = '0;
  logic          rd_valid;
  logic [CW-1:0] rd_l2_mcast, rd_l2_bcast, rd_l3_mcast, rd_l3_bcast;

  castdrop_stat #(.PORT_W(PW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_sop(hdr_sop),
    .hdr_byte(hdr_byte), .hdr_mode(hdr_mode), .hdr_port(hdr_port),
    .hdr_eoh(hdr_eoh), .hdr_drop(hdr_drop), .rd_en(rd_en), .rd_port(rd_port),
    .rd_clear(rd_clear), .rd_valid(rd_valid), .rd_l2_mcast(rd_l2_mcast),
    .rd_l2_bcast(rd_l2_bcast), .rd_l3_mcast(rd_l3_mcast), .rd_l3_bcast(rd_l3_bcast)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0]    pk [64];
  int            pk_len;
  // expected counters: index 0 l2 mcast, 1 l2 bcast, 2 l3 mcast, 3 l3 bcast
  logic [CW-1:0] exp_cnt [NP][4];

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected classes, written straight from the requirements
  function automatic logic [3:0] expect_kind(input logic md);
    logic [3:0] m;
    int v;
    int pos;
    bit all1;
    m = '0;
    v = 0;
    if (!md) begin
      if (pk_len >= 6) begin
        all1 = 1;
        for (int i = 0; i < 6; i++) if (pk[i] != 8'hFF) all1 = 0;
        m[1] = all1;
        m[0] = pk[0][0] && !all1;
      end
      if (pk_len >= 14) begin
        if ({pk[12], pk[13]} == 16'h0800) v = 4;
        if ({pk[12], pk[13]} == 16'h86DD) v = 6;
      end
      pos = 14 + ((v == 6) ? 24 : 16);
    end else begin
      if (pk_len >= 1 && pk[0][7:4] == 4'h4) v = 4;
      if (pk_len >= 1 && pk[0][7:4] == 4'h6) v = 6;
      pos = (v == 6) ? 24 : 16;
    end
    if (v != 0 && pk_len > pos) begin
      m[2] = (v == 4) ? (pk[pos][7:4] == 4'hE) : (pk[pos] == 8'hFF);
      m[3] = (v == 4) && (pk[pos] == 8'hFF);
    end
    return m;
  endfunction

  task automatic build_eth(input logic [47:0] da, input logic [15:0] et,
                           input logic [7:0] dst, input int len);
    for (int i = 0; i < 64; i++) pk[i] = 8'h00;
    for (int i = 0; i < 6; i++) pk[i] = da[47-8*i -: 8];
    pk[12] = et[15:8];
    pk[13] = et[7:0];
    pk[14] = (et == 16'h86DD) ? 8'h60 : 8'h45;
    if (et == 16'h86DD) pk[38] = dst;
    else                pk[30] = dst;
    pk_len = len;
  endtask

  task automatic build_ip(input logic [7:0] b0, input logic [7:0] dst, input int len);
    for (int i = 0; i < 64; i++) pk[i] = 8'h00;
    pk[0] = b0;
    if (b0[7:4] == 4'h6) pk[24] = dst;
    else                 pk[16] = dst;
    pk_len = len;
  endtask

  task automatic stream_hdr(input logic md, input logic [PW-1:0] port);
    for (int i = 0; i < pk_len; i++) begin
      hdr_valid = 1'b1;
      hdr_sop   = (i == 0);
      hdr_byte  = pk[i];
      hdr_mode  = md;
      hdr_port  = port;
      @(negedge clk);
    end
    hdr_valid = 1'b0;
    hdr_sop   = 1'b0;
  endtask

  task automatic send_pkt(input logic md, input logic [PW-1:0] port, input logic drop);
    logic [3:0] m;
    stream_hdr(md, port);
    hdr_eoh  = 1'b1;
    hdr_drop = drop;
    @(negedge clk);
    hdr_eoh  = 1'b0;
    hdr_drop = 1'b0;
    @(negedge clk);
    m = expect_kind(md);
    if (drop) for (int k = 0; k < 4; k++) if (m[k]) exp_cnt[port][k] = exp_cnt[port][k] + 1'b1;
  endtask

  task automatic read_port(input logic [PW-1:0] port, input logic clr, input string req);
    rd_en    = 1'b1;
    rd_port  = port;
    rd_clear = clr;
    @(negedge clk);
    rd_en    = 1'b0;
    rd_clear = 1'b0;
    check_eq(req, "rd_valid", 32'(rd_valid), 32'd1);
    check_eq(req, $sformatf("p%0d l2_mcast", port), 32'(rd_l2_mcast), 32'(exp_cnt[port][0]));
    check_eq(req, $sformatf("p%0d l2_bcast", port), 32'(rd_l2_bcast), 32'(exp_cnt[port][1]));
    check_eq(req, $sformatf("p%0d l3_mcast", port), 32'(rd_l3_mcast), 32'(exp_cnt[port][2]));
    check_eq(req, $sformatf("p%0d l3_bcast", port), 32'(rd_l3_bcast), 32'(exp_cnt[port][3]));
    if (clr) for (int k = 0; k < 4; k++) exp_cnt[port][k] = '0;
  endtask

  task automatic t_reset;
    check_eq("R1", "rd_valid idle", 32'(rd_valid), 32'd0);
    for (int p = 0; p < NP; p++) read_port(PW'(p), 1'b0, "R1");
  endtask

  task automatic t_l2_bcast;
    build_eth(48'hFFFF_FFFF_FFFF, 16'h0806, 8'h00, 20);
    send_pkt(1'b0, 3'd1, 1'b1);
    check_eq("R2", "model l2_bcast", 32'(exp_cnt[1][1]), 32'd1);
    read_port(3'd1, 1'b0, "R2");
  endtask

  task automatic t_l2_mcast;
    build_eth(48'h0100_5E00_0001, 16'h88CC, 8'h00, 20);
    send_pkt(1'b0, 3'd2, 1'b1);
    build_eth(48'h0100_5E00_0001, 16'h88CC, 8'h00, 4);   // short: no class
    send_pkt(1'b0, 3'd2, 1'b1);
    build_eth(48'h0200_0000_0001, 16'h88CC, 8'h00, 20);  // unicast
    send_pkt(1'b0, 3'd2, 1'b1);
    check_eq("R3", "model l2_mcast", 32'(exp_cnt[2][0]), 32'd1);
    read_port(3'd2, 1'b0, "R3");
  endtask

  task automatic t_l3_link_mode;
    build_eth(48'h0200_0000_0001, 16'h0800, 8'hE0, 40);
    send_pkt(1'b0, 3'd3, 1'b1);                          // R4 v4 multicast
    build_eth(48'h0200_0000_0001, 16'h0800, 8'hFF, 40);
    send_pkt(1'b0, 3'd3, 1'b1);                          // R5 v4 broadcast
    build_eth(48'h0200_0000_0001, 16'h86DD, 8'hFF, 48);
    send_pkt(1'b0, 3'd3, 1'b1);                          // R4/R5 v6: mcast only
    build_eth(48'h0200_0000_0001, 16'h0801, 8'hE0, 40);
    pk[30] = 8'hE0;
    send_pkt(1'b0, 3'd3, 1'b1);                          // R7 not IP
    check_eq("R4", "model l3_mcast", 32'(exp_cnt[3][2]), 32'd2);
    check_eq("R5", "model l3_bcast", 32'(exp_cnt[3][3]), 32'd1);
    read_port(3'd3, 1'b0, "R4 R5 R7");
  endtask

  task automatic t_ip_mode;
    build_ip(8'h45, 8'hEF, 24);
    send_pkt(1'b1, 3'd4, 1'b1);                          // R4
    build_ip(8'h45, 8'hFF, 24);
    send_pkt(1'b1, 3'd4, 1'b1);                          // R5
    build_ip(8'h61, 8'hFF, 32);
    for (int i = 1; i < 6; i++) pk[i] = 8'hFF;
    send_pkt(1'b1, 3'd4, 1'b1);                          // R6: looks like L2 bcast/mcast
    build_ip(8'h55, 8'hE0, 24);
    send_pkt(1'b1, 3'd4, 1'b1);                          // R7 bad version
    check_eq("R6", "model l2 zero", 32'(exp_cnt[4][0] | exp_cnt[4][1]), 32'd0);
    read_port(3'd4, 1'b0, "R6 R4 R7");
  endtask

  task automatic t_no_drop;
    build_eth(48'hFFFF_FFFF_FFFF, 16'h0800, 8'hFF, 40);
    send_pkt(1'b0, 3'd1, 1'b0);
    read_port(3'd1, 1'b0, "R9");
  endtask

  task automatic t_ports;
    build_eth(48'hFFFF_FFFF_FFFF, 16'h0800, 8'hE1, 40);
    send_pkt(1'b0, 3'd6, 1'b1);
    send_pkt(1'b0, 3'd0, 1'b1);
    read_port(3'd6, 1'b0, "R8");
    read_port(3'd0, 1'b0, "R8");
    read_port(3'd5, 1'b0, "R8");
  endtask

  task automatic t_clear;
    read_port(3'd3, 1'b0, "R11");
    read_port(3'd3, 1'b0, "R11");   // no clear: unchanged
    read_port(3'd3, 1'b1, "R11");   // returns values, then zero
    read_port(3'd3, 1'b0, "R11");
  endtask

  task automatic t_collision;
    build_eth(48'hFFFF_FFFF_FFFF, 16'h0806, 8'h00, 8);
    send_pkt(1'b0, 3'd5, 1'b1);
    send_pkt(1'b0, 3'd5, 1'b1);
    stream_hdr(1'b0, 3'd5);
    hdr_eoh  = 1'b1;
    hdr_drop = 1'b1;
    @(negedge clk);                 // event latched at this edge
    hdr_eoh  = 1'b0;
    hdr_drop = 1'b0;
    rd_en    = 1'b1;
    rd_port  = 3'd5;
    rd_clear = 1'b1;
    @(negedge clk);                 // increment and clear at the same edge
    rd_en    = 1'b0;
    rd_clear = 1'b0;
    check_eq("R12", "pre-value l2_bcast", 32'(rd_l2_bcast), 32'd2);
    for (int k = 0; k < 4; k++) exp_cnt[5][k] = '0;
    exp_cnt[5][1] = 8'd1;
    read_port(3'd5, 1'b0, "R12");
  endtask

  task automatic t_wrap;
    read_port(3'd7, 1'b1, "R13");
    build_eth(48'hFFFF_FFFF_FFFF, 16'h0806, 8'h00, 6);
    for (int n = 0; n < (1 << CW) + 1; n++) send_pkt(1'b0, 3'd7, 1'b1);
    check_eq("R13", "model wrap", 32'(exp_cnt[7][1]), 32'd1);
    read_port(3'd7, 1'b0, "R13");
  endtask

  initial begin
    for (int p = 0; p < NP; p++) for (int k = 0; k < 4; k++) exp_cnt[p][k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_l2_bcast();
    t_l2_mcast();
    t_l3_link_mode();
    t_ip_mode();
    t_no_drop();
    t_ports();
    t_clear();
    t_collision();
    t_wrap();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule